// File: doc/BRIEF.md
# Current-Sense ADC Conversion Controller

This block is the digital control side of a current-measurement converter. A host reaches it through a byte-wide register port. The host selects a channel and an averaging depth, powers the converter and sets a request bit. It then waits for the status pair to show a finished conversion, or for the one-cycle interrupt, and reads the 16-bit result. A single access returns two neighbouring bytes, so the whole result can be fetched in one read.

The analog side is modelled by a stand-in engine. It counts a conversion time that grows with the power-of-two averaging depth. When the count ends, it captures the value on its sample input. The block also answers with fixed identity bytes. It holds a reset-control byte that can only be written right after a one-shot unlock key.

Top module: `cadc_ctrl`

## Requirements
- R1: Offset 0x01 reads 0x01, offset 0x04 reads 0x08 and offset 0x05 reads 0x03. Writes to these offsets change nothing.
- R2: A write with bit 7 set to offset 0x52 starts a conversion only when all of these hold: bit 7 of offset 0x46 is set, no conversion is running, and the channel byte at offset 0x48 is 0, 1, 3, 5 or 6. Otherwise the write is ignored and the status is unchanged.
- R3: Status offset 0x08 has done in bit 0 and pending in bit 1. An accepted start makes the status read 0b10. Exactly L clock edges after the accepting edge it reads 0b01, and the result holds the value of `conv_in` sampled at that edge.
- R4: L equals BASE_CYCLES times 2^N when bit 7 of offset 0x5B is set, where N is bits 2:0 of offset 0x5A. When that bit is clear, L equals BASE_CYCLES.
- R5: `eoc_irq` is high for exactly the one cycle in which the status first reads 0b01 after a conversion, and low otherwise.
- R6: A write to offset 0x46 with bit 7 clear stops any running conversion and sets the status to 0b00. It raises no interrupt and leaves the result unchanged.
- R7: The result low byte is at offset 0x60 and the high byte at offset 0x61. `rd_pair` returns {byte at addr+1, byte at addr}. Unmapped offsets read 0.
- R8: A write to offset 0xDA takes effect only if the write just before it was 0xA5 to offset 0xD0. Every other write, including a second write to 0xDA, closes that unlock.
- R9: `warm_follow` equals bit 2 of the byte at offset 0xDA.
- R10: Offsets 0x40, 0x46, 0x48, 0x50, 0x5A and 0x5B read back the last byte written to them, and all of them reset to 0. Offset 0x52 reads the pending flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rd_pair | output | 16 | {byte at addr+1, byte at addr}, combinational |
| conv_in | input | 16 | Stand-in converter sample, captured when a conversion ends |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| warm_follow | output | 1 | Warm-reset follow flag from the protected register |

## Verification
The bench builds the block with BASE_CYCLES = 6 and AVG_BITS = 3, so a conversion takes between 6 and 768 cycles. That short base lets the bench count every edge of a conversion in a few hundred cycles. It also brings the deepest averaging setting, N = 7, within reach. With these values the bench checks the pending window, the exact edge on which the status turns to done, and that the interrupt lasts one cycle. It also runs an abort part-way through a conversion and shows that `conv_in` is taken at the final edge and not at the start.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
  localparam logic [7:0] A_REV    = 8'h01;
  localparam logic [7:0] A_TYPE   = 8'h04;
  localparam logic [7:0] A_SUB    = 8'h05;
  localparam logic [7:0] A_STAT   = 8'h08;
  localparam logic [7:0] A_MODE   = 8'h40;
  localparam logic [7:0] A_ENA    = 8'h46;
  localparam logic [7:0] A_CHAN   = 8'h48;
  localparam logic [7:0] A_DIG    = 8'h50;
  localparam logic [7:0] A_REQ    = 8'h52;
  localparam logic [7:0] A_NAVG   = 8'h5A;
  localparam logic [7:0] A_AVGON  = 8'h5B;
  localparam logic [7:0] A_RES_LO = 8'h60;
  localparam logic [7:0] A_RES_HI = 8'h61;
  localparam logic [7:0] A_KEY    = 8'hD0;
  localparam logic [7:0] A_RCTL   = 8'hDA;

  localparam logic [7:0] KEY_VAL  = 8'hA5;
  localparam logic [7:0] REV_VAL  = 8'h01;
  localparam logic [7:0] TYPE_VAL = 8'h08;
  localparam logic [7:0] SUB_VAL  = 8'h03;

  // accepted measurement channel codes
  function automatic logic chan_ok(input logic [7:0] c);
    case (c)
      8'd0, 8'd1, 8'd3, 8'd5, 8'd6: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  // conversion length in cycles: base scaled by 2^n when averaging is on
  function automatic int unsigned conv_len(input int unsigned base,
                                           input int unsigned n,
                                           input logic on);
    return on ? (base << n) : base;
  endfunction
endpackage

// File: rtl/cadc_engine.sv
module cadc_engine #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] len,
  input  logic [15:0]   res_in,
  output logic          busy,
  output logic          done,
  output logic [15:0]   result
);
  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      result <= '0;
    end else begin
      if (abort)          cnt_q <= '0;
      else if (start)     cnt_q <= len;
      else if (busy)      cnt_q <= cnt_q - CW'(1);
      if (done)           result <= res_in;
    end
  end
endmodule

// File: rtl/cadc_regs.sv
module cadc_regs
  import cadc_pkg::*;
#(
  parameter int AVG_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [7:0]          wdata,
  input  logic                busy,
  input  logic                done,
  input  logic [15:0]         result,
  output logic [15:0]         rd_pair,
  output logic                start,
  output logic                abort,
  output logic [AVG_BITS-1:0] n_avg,
  output logic                avg_on,
  output logic                eoc,
  output logic                irq,
  output logic                unlocked,
  output logic [7:0]          rctl,
  output logic                enabled
);
  logic [7:0] mode_q, ena_q, chan_q, dig_q, navg_q, avgon_q;

  assign enabled = ena_q[7];
  assign n_avg   = navg_q[AVG_BITS-1:0];
  assign avg_on  = avgon_q[7];
  assign start   = wr_en && (addr == A_REQ) && wdata[7] && enabled
                   && !busy && chan_ok(chan_q);
  assign abort   = wr_en && (addr == A_ENA) && !wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ena_q <= '0; chan_q <= '0; dig_q <= '0;
      navg_q <= '0; avgon_q <= '0; rctl <= '0;
      unlocked <= 1'b0; eoc <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= done;
      if (start || abort) eoc <= 1'b0;
      else if (done)      eoc <= 1'b1;
      if (wr_en) begin
        unlocked <= (addr == A_KEY) && (wdata == KEY_VAL);
        case (addr)
          A_MODE:  mode_q  <= wdata;
          A_ENA:   ena_q   <= wdata;
          A_CHAN:  chan_q  <= wdata;
          A_DIG:   dig_q   <= wdata;
          A_NAVG:  navg_q  <= wdata;
          A_AVGON: avgon_q <= wdata;
          A_RCTL:  if (unlocked) rctl <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] la;
    logic [7:0] lb;
    assign la = addr + 8'(g);
    always_comb begin
      case (la)
        A_REV:    lb = REV_VAL;
        A_TYPE:   lb = TYPE_VAL;
        A_SUB:    lb = SUB_VAL;
        A_STAT:   lb = {6'b0, busy, eoc};
        A_MODE:   lb = mode_q;
        A_ENA:    lb = ena_q;
        A_CHAN:   lb = chan_q;
        A_DIG:    lb = dig_q;
        A_REQ:    lb = {busy, 7'b0};
        A_NAVG:   lb = navg_q;
        A_AVGON:  lb = avgon_q;
        A_RES_LO: lb = result[7:0];
        A_RES_HI: lb = result[15:8];
        A_RCTL:   lb = rctl;
        default:  lb = 8'h00;
      endcase
    end
    assign rd_pair[8*g +: 8] = lb;
  end
endmodule

// File: rtl/cadc_ctrl.sv
module cadc_ctrl
  import cadc_pkg::*;
#(
  parameter int BASE_CYCLES = 20,
  parameter int AVG_BITS    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [15:0] rd_pair,
  input  logic [15:0] conv_in,
  output logic        eoc_irq,
  output logic        warm_follow
);
  localparam int MAXN    = (1 << AVG_BITS) - 1;
  localparam int MAX_LEN = BASE_CYCLES << MAXN;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic                start_req, abort_req, eng_busy, eng_done;
  logic                eoc_flag, key_open, ena_bit, avg_on;
  logic [AVG_BITS-1:0] n_avg;
  logic [7:0]          rctl_q;
  logic [15:0]         result;
  logic [CW-1:0]       len;

  assign len         = CW'(conv_len(BASE_CYCLES, 32'(n_avg), avg_on));
  assign warm_follow = rctl_q[2];

  cadc_regs #(.AVG_BITS(AVG_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(eng_busy), .done(eng_done), .result(result), .rd_pair(rd_pair),
    .start(start_req), .abort(abort_req), .n_avg(n_avg), .avg_on(avg_on),
    .eoc(eoc_flag), .irq(eoc_irq), .unlocked(key_open), .rctl(rctl_q),
    .enabled(ena_bit)
  );

  cadc_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_req), .abort(abort_req),
    .len(len), .res_in(conv_in), .busy(eng_busy), .done(eng_done),
    .result(result)
  );
endmodule

// File: rtl/cadc_checks.sv
module cadc_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       eoc_irq,
  input logic       busy,
  input logic       eoc,
  input logic       unlocked,
  input logic [7:0] rctl,
  input logic       enabled
);
  a_r3_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && eoc));
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);
  a_r5_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> (eoc && !busy));
  a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h52 && wdata[7] && !enabled && !busy) |=> !busy);
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h46 && !wdata[7]) |=> (!busy && !eoc && !eoc_irq));
  a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'hDA && !unlocked) |=> $stable(rctl));
endmodule

bind cadc_ctrl cadc_checks u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .eoc_irq(eoc_irq), .busy(eng_busy), .eoc(eoc_flag), .unlocked(key_open),
  .rctl(rctl_q), .enabled(ena_bit)
);

// File: tb/test_cadc_ctrl.sv
module test_cadc_ctrl;
  localparam int BASE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [15:0] rd_pair;
  logic [15:0] conv_in = 16'h0000;
  logic        eoc_irq;
  logic        warm_follow;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  cadc_ctrl #(.BASE_CYCLES(BASE), .AVG_BITS(3)) i_cadc_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_pair(rd_pair), .conv_in(conv_in), .eoc_irq(eoc_irq),
    .warm_follow(warm_follow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rd_pair;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [15:0] v;
    rd(a, v);
    chk(v[7:0] == exp, tag, v[7:0], exp);
  endtask

  // wait one accepted conversion of length len, checking edge by edge
  task automatic run_conv(input int len, input string tag);
    logic [15:0] v;
    bit early = 1'b0;
    int bad_v = 0;
    rd(8'h08, v);
    chk(v[1:0] == 2'b10, {tag, " pending after start"}, v[1:0], 2);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      rd(8'h08, v);
      if (v[1:0] != 2'b10 || eoc_irq) begin early = 1'b1; bad_v = v[1:0]; end
    end
    chk(!early, {tag, " pending window"}, bad_v, 2);
    @(negedge clk);
    rd(8'h08, v);
    chk(v[1:0] == 2'b01, {tag, " done at exact edge"}, v[1:0], 1);
    chk(eoc_irq == 1'b1, {tag, " R5 irq high"}, eoc_irq, 1);
    @(negedge clk);
    chk(eoc_irq == 1'b0, {tag, " R5 irq one cycle"}, eoc_irq, 0);
  endtask

  task automatic t_reset();
    rd_chk(8'h01, 8'h01, "R1 revision");
    rd_chk(8'h04, 8'h08, "R1 type");
    rd_chk(8'h05, 8'h03, "R1 subtype");
    rd_chk(8'h08, 8'h00, "R3 status reset");
    rd_chk(8'h46, 8'h00, "R10 enable reset");
    rd_chk(8'h5A, 8'h00, "R10 avg reset");
    rd_chk(8'hDA, 8'h00, "R8 rctl reset");
    chk(warm_follow == 1'b0, "R9 warm reset", warm_follow, 0);
    chk(eoc_irq == 1'b0, "R5 irq reset", eoc_irq, 0);
  endtask

  task automatic t_ident_ro();
    wr(8'h01, 8'hFF); wr(8'h04, 8'hFF); wr(8'h05, 8'h00);
    rd_chk(8'h01, 8'h01, "R1 revision after write");
    rd_chk(8'h04, 8'h08, "R1 type after write");
    rd_chk(8'h05, 8'h03, "R1 subtype after write");
  endtask

  task automatic t_readback();
    wr(8'h40, 8'h19); wr(8'h50, 8'h0C); wr(8'h48, 8'h03); wr(8'h5B, 8'h00);
    rd_chk(8'h40, 8'h19, "R10 mode readback");
    rd_chk(8'h50, 8'h0C, "R10 dig readback");
    rd_chk(8'h48, 8'h03, "R10 chan readback");
    rd_chk(8'h33, 8'h00, "R7 unmapped");
  endtask

  task automatic t_basic();
    logic [15:0] v;
    wr(8'h46, 8'h80);
    wr(8'h48, 8'h01);
    conv_in = 16'h1111;
    wr(8'h52, 8'h80);
    rd_chk(8'h52, 8'h80, "R10 request pending bit");
    conv_in = 16'hBEEF;              // value present at the final edge wins
    run_conv(BASE, "R3 basic");
    rd(8'h60, v);
    chk(v == 16'hBEEF, "R7 result pair", v, 16'hBEEF);
    rd(8'h61, v);
    chk(v[7:0] == 8'hBE, "R7 high byte", v[7:0], 8'hBE);
  endtask

  task automatic t_avg();
    wr(8'h5A, 8'h03); wr(8'h5B, 8'h00);
    conv_in = 16'h0203;
    wr(8'h52, 8'h80);
    run_conv(BASE, "R4 averaging off");
    wr(8'h5B, 8'h80);
    wr(8'h52, 8'h80);
    run_conv(BASE * 8, "R4 N=3");
    wr(8'h5A, 8'h07);
    wr(8'h52, 8'h80);
    run_conv(BASE * 128, "R4 N=7");
    wr(8'h5A, 8'h00);
    wr(8'h52, 8'h80);
    run_conv(BASE, "R4 N=0");
    wr(8'h5B, 8'h00);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    wr(8'h52, 8'h40);                // bit 7 clear: no start
    rd_chk(8'h08, 8'h01, "R2 no bit7 ignored");
    wr(8'h48, 8'h02);
    wr(8'h52, 8'h80);
    rd_chk(8'h08, 8'h01, "R2 channel 2 ignored");
    wr(8'h48, 8'h06);
    wr(8'h46, 8'h00);
    wr(8'h52, 8'h80);
    rd_chk(8'h08, 8'h00, "R2 disabled ignored");
    repeat (BASE + 2) @(negedge clk);
    rd(8'h08, v);
    chk(v[1:0] == 2'b00 && !eoc_irq, "R2 disabled stays idle", v[1:0], 0);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    bit irq_seen = 1'b0;
    wr(8'h46, 8'h80);
    wr(8'h48, 8'h05);
    conv_in = 16'h7777;
    wr(8'h52, 8'h80);
    wr(8'h52, 8'h80);                // second request while busy: ignored
    rd_chk(8'h08, 8'h02, "R2 busy request ignored");
    wr(8'h46, 8'h00);
    rd_chk(8'h08, 8'h00, "R6 abort status");
    for (int k = 0; k < BASE + 4; k++) begin
      @(negedge clk);
      if (eoc_irq) irq_seen = 1'b1;
    end
    chk(!irq_seen, "R6 no irq after abort", irq_seen, 0);
    rd(8'h60, v);
    chk(v == 16'h0203, "R6 result unchanged", v, 16'h0203);
  endtask

  task automatic t_key();
    wr(8'hDA, 8'h04);
    rd_chk(8'hDA, 8'h00, "R8 write without key");
    wr(8'hD0, 8'hA5); wr(8'h40, 8'h00); wr(8'hDA, 8'h04);
    rd_chk(8'hDA, 8'h00, "R8 key closed by other write");
    wr(8'hD0, 8'h5A); wr(8'hDA, 8'h04);
    rd_chk(8'hDA, 8'h00, "R8 wrong key");
    wr(8'hD0, 8'hA5); wr(8'hDA, 8'h04);
    rd_chk(8'hDA, 8'h04, "R8 keyed write");
    chk(warm_follow == 1'b1, "R9 warm set", warm_follow, 1);
    wr(8'hDA, 8'h00);
    rd_chk(8'hDA, 8'h04, "R8 key is one-shot");
    wr(8'hD0, 8'hA5); wr(8'hDA, 8'h00);
    chk(warm_follow == 1'b0, "R9 warm clear", warm_follow, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ident_ro();
    t_readback();
    t_basic();
    t_avg();
    t_ignored();
    t_abort();
    t_key();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule